// File: doc/BRIEF.md
# Bus DMA Master with Request/Grant Acquisition

This block carries out DMA bursts on an asynchronous, handshaked backplane bus on behalf of a local requester. A burst is given as a start address, a word count and a direction. The block first wins the bus through the non-processor request handshake. It raises a request line, waits for the grant and then holds a selection-acknowledge line for as long as it owns the bus. It then runs one full master cycle per word, either a read or a write. Each cycle has an address setup phase, a master-sync strobe and a wait for the slave-sync reply.

Every word becomes a real cycle on the bus, even when the target is memory that a slave in the same device emulates. Caches that snoop the bus and logic analysers therefore see every access. A configuration input selects a mode for backplanes that have no processor. In that mode nobody arbitrates, so the block skips the request/grant exchange and starts cycles at once. If no slave answers a cycle within a fixed number of clocks, the burst is abandoned and the address that failed is reported.

Top module: `dma_bus_master`

## Requirements
- R1: After reset, bus_req, bus_sack, bus_msync, bus_drive, bus_dout_en and done are 0, and req_ready is 1.
- R2: With cfg_no_arb=0, an accepted burst raises bus_req. On the clock edge after bus_grant is seen high, bus_sack rises and bus_req falls in the same edge. bus_sack stays high across all cycles of the burst and falls in the same edge that done rises. bus_msync is high only while bus_sack is high.
- R3: With cfg_no_arb=1, bus_req never rises. bus_msync first goes high 4 clock edges after the edge that accepts the request (req_valid=1 while req_ready=1).
- R4: bus_addr is valid with bus_drive=1 for at least 2 clocks before bus_msync rises, and it does not change while bus_msync is high.
- R5: In a write burst (req_write=1), wr_ack is high for one clock per word. The word's data is taken from wr_data in that clock and is presented on bus_dout with bus_dout_en=1.
- R6: In a read burst, each completed word is delivered on rd_data with a one-clock rd_valid pulse, in address order.
- R7: Word k of a burst uses address start+2k. Every word produces exactly one bus_msync pulse, whatever the address, with no internal shortcut.
- R8: If bus_ssync stays low for 64 clocks of bus_msync high, bus_msync drops and the rest of the burst is abandoned. done then pulses with done_err=1, and err_addr holds the address of the failed word.
- R9: done is a single-clock pulse. done_err is 0 with done for a burst in which every word completed.
- R10: A request with req_count=0 produces done on the next clock with done_err=0 and no bus activity.
- R11: bus_msync falls after bus_ssync is seen high. The next cycle's strobe does not rise while bus_ssync is still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_no_arb | input | 1 | 1: no arbiter present, skip request/grant |
| req_valid | input | 1 | Burst request |
| req_ready | output | 1 | Block idle, request accepted when both high |
| req_addr | input | AW | Start byte address |
| req_count | input | CW | Word count |
| req_write | input | 1 | 1: write burst, 0: read burst |
| wr_data | input | DW | Write data for the current word |
| wr_ack | output | 1 | wr_data is taken in this clock |
| rd_data | output | DW | Read word |
| rd_valid | output | 1 | rd_data valid pulse |
| done | output | 1 | Burst finished pulse |
| done_err | output | 1 | Burst ended by slave timeout |
| err_addr | output | AW | Address of the word that timed out |
| bus_req | output | 1 | Bus mastership request |
| bus_grant | input | 1 | Grant from arbiter |
| bus_sack | output | 1 | Selection acknowledge / bus owned |
| bus_drive | output | 1 | Address and control lines enabled |
| bus_addr | output | AW | Bus address |
| bus_write | output | 1 | Cycle type, 1: write |
| bus_dout | output | DW | Write data to bus |
| bus_dout_en | output | 1 | Data lines driven |
| bus_msync | output | 1 | Master sync strobe |
| bus_ssync | input | 1 | Slave sync reply |
| bus_din | input | DW | Read data from bus |

## Verification
In the no-arbiter case the strobe is due on the 4th edge after the request is accepted. The bench counts edges from that point and checks the exact value. The address setup time and the strobe length on a timeout are counted in clocks by a monitor that samples on falling edges; the timeout strobe must last exactly 64 clocks. Handshake-paced results, such as read words, done and the release of bus ownership, do not have a fixed latency. They are awaited with bounded loops and checked for count, order and value once done is seen.

// File: rtl/dmb_pkg.sv
package dmb_pkg;
  typedef enum logic [1:0] {A_IDLE, A_REQ, A_OWN} acq_state_t;
  typedef enum logic [1:0] {C_IDLE, C_SETUP, C_SYNC, C_END} cyc_state_t;
  typedef enum logic [1:0] {B_IDLE, B_ACQ, B_ISSUE, B_WAIT} burst_state_t;
endpackage

// File: rtl/dmb_acquire.sv
module dmb_acquire import dmb_pkg::*; (
  input  logic clk,
  input  logic rst,
  input  logic no_arb,
  input  logic want,
  input  logic drop,
  input  logic grant,
  output logic bus_req,
  output logic bus_sack,
  output logic owned
);
  acq_state_t st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= A_IDLE;
      bus_req  <= 1'b0;
      bus_sack <= 1'b0;
    end else begin
      case (st)
        A_IDLE: if (want) begin
          if (no_arb) st <= A_OWN;
          else begin
            bus_req <= 1'b1;
            st      <= A_REQ;
          end
        end
        A_REQ: if (grant) begin
          bus_req  <= 1'b0;
          bus_sack <= 1'b1;
          st       <= A_OWN;
        end
        A_OWN: if (drop) begin
          bus_sack <= 1'b0;
          st       <= A_IDLE;
        end
        default: st <= A_IDLE;
      endcase
    end
  end

  assign owned = (st == A_OWN);
endmodule

// File: rtl/dmb_cycle.sv
module dmb_cycle import dmb_pkg::*; #(
  parameter int AW = 18,
  parameter int DW = 16,
  parameter int SETUP_CLKS = 2,
  parameter int TIMEOUT_CLKS = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          ssync,
  input  logic [DW-1:0] din,
  output logic [AW-1:0] bus_addr,
  output logic          bus_write,
  output logic [DW-1:0] bus_dout,
  output logic          bus_drive,
  output logic          bus_dout_en,
  output logic          msync,
  output logic [DW-1:0] rdata,
  output logic          cyc_done,
  output logic          cyc_err
);
  localparam int CMAX = (TIMEOUT_CLKS > SETUP_CLKS) ? TIMEOUT_CLKS : SETUP_CLKS;
  localparam int CNTW = $clog2(CMAX + 1);
  localparam logic [CNTW-1:0] SET_LAST = CNTW'(SETUP_CLKS - 1);
  localparam logic [CNTW-1:0] TO_LAST  = CNTW'(TIMEOUT_CLKS - 1);

  cyc_state_t      st;
  logic [CNTW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= C_IDLE;
      cnt         <= '0;
      bus_addr    <= '0;
      bus_write   <= 1'b0;
      bus_dout    <= '0;
      bus_drive   <= 1'b0;
      bus_dout_en <= 1'b0;
      msync       <= 1'b0;
      rdata       <= '0;
      cyc_done    <= 1'b0;
      cyc_err     <= 1'b0;
    end else begin
      cyc_done <= 1'b0;
      cyc_err  <= 1'b0;
      case (st)
        C_IDLE: if (start) begin
          bus_addr    <= addr;
          bus_write   <= wr;
          bus_dout    <= wdata;
          bus_drive   <= 1'b1;
          bus_dout_en <= wr;
          cnt         <= '0;
          st          <= C_SETUP;
        end
        C_SETUP: begin
          if (cnt == SET_LAST) begin
            msync <= 1'b1;
            cnt   <= '0;
            st    <= C_SYNC;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        C_SYNC: begin
          if (ssync) begin
            if (!bus_write) rdata <= din;
            msync <= 1'b0;
            st    <= C_END;
          end else if (cnt == TO_LAST) begin
            msync       <= 1'b0;
            bus_drive   <= 1'b0;
            bus_dout_en <= 1'b0;
            cyc_done    <= 1'b1;
            cyc_err     <= 1'b1;
            st          <= C_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        C_END: if (!ssync) begin
          bus_drive   <= 1'b0;
          bus_dout_en <= 1'b0;
          cyc_done    <= 1'b1;
          st          <= C_IDLE;
        end
        default: st <= C_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_bus_master.sv
module dma_bus_master import dmb_pkg::*; #(
  parameter int AW = 18,
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int SETUP_CLKS = 2,
  parameter int TIMEOUT_CLKS = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_no_arb,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [CW-1:0] req_count,
  input  logic          req_write,
  input  logic [DW-1:0] wr_data,
  output logic          wr_ack,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          done,
  output logic          done_err,
  output logic [AW-1:0] err_addr,
  output logic          bus_req,
  input  logic          bus_grant,
  output logic          bus_sack,
  output logic          bus_drive,
  output logic [AW-1:0] bus_addr,
  output logic          bus_write,
  output logic [DW-1:0] bus_dout,
  output logic          bus_dout_en,
  output logic          bus_msync,
  input  logic          bus_ssync,
  input  logic [DW-1:0] bus_din
);
  localparam logic [AW-1:0] WORD_STEP = AW'(2);
  localparam logic [CW-1:0] ONE_LEFT  = CW'(1);

  burst_state_t  st;
  logic [AW-1:0] cur_addr;
  logic [CW-1:0] left;
  logic          wr_r;
  logic          owned, acq_want, acq_drop, last_word;
  logic          cyc_start, cyc_done, cyc_err;

  assign last_word = (left == ONE_LEFT);
  assign acq_want  = (st == B_IDLE) && req_valid && (req_count != '0);
  assign acq_drop  = (st == B_WAIT) && cyc_done && (cyc_err || last_word);
  assign cyc_start = (st == B_ISSUE);
  assign req_ready = (st == B_IDLE);
  assign wr_ack    = cyc_start && wr_r;
  assign rd_valid  = cyc_done && !cyc_err && !wr_r;

  dmb_acquire u_acq (
    .clk(clk), .rst(rst), .no_arb(cfg_no_arb), .want(acq_want), .drop(acq_drop),
    .grant(bus_grant), .bus_req(bus_req), .bus_sack(bus_sack), .owned(owned)
  );

  dmb_cycle #(.AW(AW), .DW(DW), .SETUP_CLKS(SETUP_CLKS), .TIMEOUT_CLKS(TIMEOUT_CLKS)) u_cyc (
    .clk(clk), .rst(rst), .start(cyc_start), .addr(cur_addr), .wr(wr_r), .wdata(wr_data),
    .ssync(bus_ssync), .din(bus_din), .bus_addr(bus_addr), .bus_write(bus_write),
    .bus_dout(bus_dout), .bus_drive(bus_drive), .bus_dout_en(bus_dout_en),
    .msync(bus_msync), .rdata(rd_data), .cyc_done(cyc_done), .cyc_err(cyc_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= B_IDLE;
      cur_addr <= '0;
      left     <= '0;
      wr_r     <= 1'b0;
      done     <= 1'b0;
      done_err <= 1'b0;
      err_addr <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        B_IDLE: if (req_valid) begin
          cur_addr <= req_addr;
          left     <= req_count;
          wr_r     <= req_write;
          if (req_count == '0) begin
            done     <= 1'b1;
            done_err <= 1'b0;
          end else begin
            st <= B_ACQ;
          end
        end
        B_ACQ:   if (owned) st <= B_ISSUE;
        B_ISSUE: st <= B_WAIT;
        B_WAIT: if (cyc_done) begin
          if (cyc_err) begin
            done     <= 1'b1;
            done_err <= 1'b1;
            err_addr <= cur_addr;
            st       <= B_IDLE;
          end else begin
            cur_addr <= cur_addr + WORD_STEP;
            left     <= left - 1'b1;
            if (last_word) begin
              done     <= 1'b1;
              done_err <= 1'b0;
              st       <= B_IDLE;
            end else begin
              st <= B_ISSUE;
            end
          end
        end
        default: st <= B_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_bus_master_checker.sv
module dma_bus_master_checker #(
  parameter int AW = 18,
  parameter int TIMEOUT_CLKS = 64
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_no_arb,
  input logic          done,
  input logic          bus_req,
  input logic          bus_sack,
  input logic          bus_drive,
  input logic [AW-1:0] bus_addr,
  input logic          bus_msync,
  input logic          bus_ssync
);
  localparam int RW = $clog2(TIMEOUT_CLKS + 2);
  logic [RW-1:0] hi_run;

  always_ff @(posedge clk) begin
    if (rst) hi_run <= '0;
    else if (!bus_msync) hi_run <= '0;
    else if (hi_run != {RW{1'b1}}) hi_run <= hi_run + 1'b1;
  end

  assert_req_drop_R2: assert property (@(posedge clk) disable iff (rst)
    bus_sack |-> !bus_req);
  assert_owner_R2: assert property (@(posedge clk) disable iff (rst)
    bus_msync |-> (bus_sack || cfg_no_arb));
  assert_no_req_R3: assert property (@(posedge clk) disable iff (rst)
    cfg_no_arb |-> !bus_req);
  assert_setup_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_msync) |-> ($past(bus_drive, 2) && $stable(bus_addr)
                          && ($past(bus_addr, 1) == $past(bus_addr, 2))));
  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_msync && $past(bus_msync)) |-> $stable(bus_addr));
  assert_timeout_R8: assert property (@(posedge clk) disable iff (rst)
    hi_run <= RW'(TIMEOUT_CLKS));
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_interlock_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_msync) |-> !bus_ssync);
endmodule

bind dma_bus_master dma_bus_master_checker #(.AW(AW), .TIMEOUT_CLKS(TIMEOUT_CLKS)) u_chk (
  .clk(clk), .rst(rst), .cfg_no_arb(cfg_no_arb), .done(done), .bus_req(bus_req),
  .bus_sack(bus_sack), .bus_drive(bus_drive), .bus_addr(bus_addr),
  .bus_msync(bus_msync), .bus_ssync(bus_ssync)
);

// File: tb/dma_bus_master_bench.sv
`timescale 1ns/1ps
module dma_bus_master_bench;
  localparam int AW = 18, DW = 16, CW = 16;

  logic clk = 0, rst = 1;
  logic cfg_no_arb = 0, req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [CW-1:0] req_count = '0;
  logic [DW-1:0] wr_data = '0;
  logic req_ready, wr_ack, rd_valid, done, done_err;
  logic [DW-1:0] rd_data, bus_dout, bus_din;
  logic [AW-1:0] err_addr, bus_addr;
  logic bus_req, bus_grant, bus_sack, bus_drive, bus_write, bus_dout_en, bus_msync, bus_ssync;

  always #5 clk = ~clk;

  dma_bus_master u_dma_bus_master (
    .clk(clk), .rst(rst), .cfg_no_arb(cfg_no_arb), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_count(req_count), .req_write(req_write), .wr_data(wr_data),
    .wr_ack(wr_ack), .rd_data(rd_data), .rd_valid(rd_valid), .done(done), .done_err(done_err),
    .err_addr(err_addr), .bus_req(bus_req), .bus_grant(bus_grant), .bus_sack(bus_sack),
    .bus_drive(bus_drive), .bus_addr(bus_addr), .bus_write(bus_write), .bus_dout(bus_dout),
    .bus_dout_en(bus_dout_en), .bus_msync(bus_msync), .bus_ssync(bus_ssync), .bus_din(bus_din)
  );

  // arbiter model: grant one clock after a request, withdrawn once acknowledged
  always @(posedge clk) bus_grant <= rst ? 1'b0 : (bus_req && !bus_sack);

  // slave model: 64 words at byte addresses 0..127, replies after 3 clocks
  logic [DW-1:0] mem [64];
  int sdly;
  always @(posedge clk) begin
    if (rst) begin bus_ssync <= 0; sdly <= 0; bus_din <= '0; end
    else if (!bus_msync) begin bus_ssync <= 0; sdly <= 0; end
    else if (!bus_ssync && bus_addr < 18'd128) begin
      sdly <= sdly + 1;
      if (sdly == 3) begin
        if (bus_write) mem[bus_addr[6:1]] <= bus_dout;
        else bus_din <= mem[bus_addr[6:1]];
        bus_ssync <= 1;
      end
    end
  end

  int errors = 0, total = 0, cyc = 0;
  int n_strobe, n_done, n_rd, first_hi, max_run, run, min_setup, setup, seen_req, wr_idx, wr_bad;
  int sack_at_done, max_done_run, drun;
  logic last_err; logic [AW-1:0] last_eaddr;
  logic [DW-1:0] rd_buf [8];
  logic [AW-1:0] strobe_addr [8];
  logic prev_ms, prev_drv;
  logic [DW-1:0] wbase;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic clr_mon();
    n_strobe = 0; n_done = 0; n_rd = 0; first_hi = -1; max_run = 0; run = 0;
    min_setup = 99; setup = 0; seen_req = 0; wr_idx = 0; wr_bad = 0;
    sack_at_done = 0; max_done_run = 0; drun = 0;
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (bus_req) seen_req = 1;
      if (bus_msync && !prev_ms) begin
        if (n_strobe < 8) strobe_addr[n_strobe] = bus_addr;
        n_strobe++;
        if (first_hi < 0) first_hi = cyc;
        if (setup < min_setup) min_setup = setup;
      end
      if (bus_drive && !prev_drv) setup = 0;
      if (bus_drive && !bus_msync) setup++;
      run = bus_msync ? run + 1 : 0;
      if (run > max_run) max_run = run;
      if (wr_ack) begin wr_data = wbase + DW'(wr_idx) * 16'h0111; wr_idx++; end
      if (bus_dout_en && bus_msync && bus_dout !== wbase + DW'(wr_idx - 1) * 16'h0111) wr_bad++;
      if (rd_valid) begin if (n_rd < 8) rd_buf[n_rd] = rd_data; n_rd++; end
      drun = done ? drun + 1 : 0;
      if (drun > max_done_run) max_done_run = drun;
      if (done) begin n_done++; last_err = done_err; last_eaddr = err_addr; if (bus_sack) sack_at_done = 1; end
      prev_ms = bus_msync; prev_drv = bus_drive;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  int t_acc;
  task automatic run_burst(input logic [AW-1:0] a, input int n, input logic w);
    clr_mon();
    @(negedge clk);
    req_addr = a; req_count = CW'(n); req_write = w; req_valid = 1;
    @(posedge clk); @(negedge clk);
    t_acc = cyc; req_valid = 0;
    for (int i = 0; i < 2000 && n_done == 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 bus_req", bus_req, 0); chk("R1 bus_sack", bus_sack, 0);
    chk("R1 bus_msync", bus_msync, 0); chk("R1 bus_drive", bus_drive, 0);
    chk("R1 bus_dout_en", bus_dout_en, 0); chk("R1 done", done, 0);
    chk("R1 req_ready", req_ready, 1);
  endtask

  task automatic t_write_arb();
    cfg_no_arb = 0; wbase = 16'hA500;
    run_burst(18'h010, 4, 1);
    chk("R2 request seen", seen_req, 1);
    chk("R2 sack falls with done", sack_at_done, 0);
    chk("R2 sack released", bus_sack, 0);
    chk("R5 wr_ack count", wr_idx, 4);
    chk("R5 bus_dout matches", wr_bad, 0);
    chk("R7 strobes", n_strobe, 4);
    for (int k = 0; k < 4; k++) chk("R7 address", strobe_addr[k], 18'h010 + 2 * k);
    chk("R9 done once", n_done, 1); chk("R9 done width", max_done_run, 1);
    chk("R9 no error", last_err, 0); chk("R4 setup", min_setup >= 2, 1);
  endtask

  task automatic t_read_arb();
    cfg_no_arb = 0;
    run_burst(18'h00C, 6, 0);
    chk("R6 read count", n_rd, 6);
    chk("R6 word0", rd_buf[0], 16'h1006); chk("R6 word1", rd_buf[1], 16'h1007);
    for (int k = 2; k < 6; k++) chk("R6 written word", rd_buf[k], 16'hA500 + DW'(k - 2) * 16'h0111);
    chk("R9 no error", last_err, 0);
  endtask

  task automatic t_no_arb();
    cfg_no_arb = 1;
    run_burst(18'h000, 3, 0);
    chk("R3 no request", seen_req, 0);
    chk("R3 strobe latency", first_hi - t_acc, 4);
    chk("R6 word", rd_buf[2], 16'h1002);
    chk("R7 strobes", n_strobe, 3);
    cfg_no_arb = 0;
  endtask

  task automatic t_timeout();
    cfg_no_arb = 0;
    run_burst(18'h07E, 3, 0);
    chk("R8 error flag", last_err, 1);
    chk("R8 error address", last_eaddr, 18'h080);
    chk("R8 strobe length", max_run, 64);
    chk("R8 burst aborted", n_strobe, 2);
    chk("R8 sack released", bus_sack, 0);
    chk("R6 good word", n_rd, 1);
    chk("R11 strobe low", bus_msync, 0);
  endtask

  task automatic t_zero();
    run_burst(18'h020, 0, 0);
    chk("R10 done", n_done, 1); chk("R10 no error", last_err, 0);
    chk("R10 no strobe", n_strobe, 0); chk("R10 no request", seen_req, 0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 16'h1000 + DW'(i);
    prev_ms = 0; prev_drv = 0; last_err = 0; last_eaddr = '0; wbase = '0;
    clr_mon();
    repeat (3) @(posedge clk);
    @(negedge clk); t_reset();
    rst = 0;
    t_write_arb();
    t_read_arb();
    t_no_arb();
    t_timeout();
    t_zero();
    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; total++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end
endmodule